// File: doc/BRIEF.md
# Five-Level Staircase Gate Pattern Generator

This block produces the 24 gate commands for a three-phase, five-level clamped-leg inverter that runs at fundamental switching frequency. A tick-driven period counter sweeps one fundamental cycle of `period_len` ticks; at a 10 µs tick and 60 Hz that is 1667 ticks. Each phase turns the counter position, shifted by a third of the period per phase, into one of five output levels. It does this by comparing the position against two switching instants, t1 and t2, which lie inside the first eighth of the period. The level is then expanded into four upper gates and four complementary gates.

The two instants come from an eight-entry table selected by `mi_sel`, so nothing is solved at run time. A new selection and a new period length take effect only when the counter wraps, which keeps the staircase free of glitches. Every change of a switch pair passes through a programmable break-before-make interval. Stopping the block parks the legs at mid level, and a safe-off input opens every switch.

Top module: `mls_gate_gen`

## Requirements
- R1: While `rst_n` is low, all bits of `gate_hi` and `gate_lo` are low.
- R2: Phase a uses bits 3:0, phase b uses bits 7:4 and phase c uses bits 11:8. Bit k (0..3) of a group is upper switch k+1, and it is wanted on iff the level L satisfies L >= 4-k. Once a pair has settled, its `gate_lo` bit is the inverse of its `gate_hi` bit.
- R3: Let q be the phase-a position within its half period, where half = floor(N/2). The offset from level 2 is 0 for q < t1, 1 for q < t2, 2 for q < half-t2, 1 for q < half-t1, and 0 after that. The offset is added in the first half and subtracted in the second. Table entry s gives t1 = 30+12s and t2 = 150+6s ticks. Gates appear one clock after the counter position they reflect.
- R4: Phases b and c follow the same rule as phase a, with positions lagging by floor(N/3) and 2*floor(N/3) ticks, modulo N.
- R5: The counter advances only on a clock with `tick_en` high while `run` is high, and it returns to 0 after position N-1. While running, `period_len` and `mi_sel` are captured only on that wrap. While stopped, they are captured on every clock and the counter holds at 0.
- R6: When the wanted state of a pair changes, both of its gates go off. The new gate turns on only once `dead_ticks` ticks have passed since the latest change, and a further change restarts the count. With `dead_ticks` = 0 the pair swaps in a single clock.
- R7: No pair ever has `gate_hi` and `gate_lo` high together.
- R8: With `run` low, every phase wants level 2 (upper switches 3 and 4 on, complementary switches 1 and 2 on), subject to R6.
- R9: `safe_off` high drives all 24 gates low on the next clock. After it falls, each pair waits `dead_ticks` ticks, and at least one clock, before turning a gate on.
- R10: With steady inputs and `run` high, each upper gate turns on exactly once in any window of N consecutive ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-step enable that advances the counter and the dead-time count |
| period_len | input | CNT_W | Fundamental period N in ticks |
| mi_sel | input | SEL_W | Modulation-index entry in the angle table |
| run | input | 1 | Staircase active; when low the legs park at level 2 |
| safe_off | input | 1 | Turns every gate off |
| dead_ticks | input | DT_W | Break-before-make interval in ticks |
| gate_hi | output | 3*4 | Upper switch gates, 4 per phase |
| gate_lo | output | 3*4 | Complementary switch gates, 4 per phase |

## Verification
Two events can land in the same clock: a new `mi_sel` or `period_len` arriving on the exact clock the counter wraps, and a safe-off assertion arriving on the clock a pair starts its dead interval. The bench provokes the first by changing the selection at position N-1. It provokes the second by raising `safe_off` at the moment phase a reaches t1, and random pulses during dead windows add more cases. A reference model built from the requirements judges the result cycle by cycle. The wrap case must show the new angles from position 0. The collision case must show all gates off with no stray pulse, followed by a full dead interval after release.

// File: rtl/mls_pkg.sv
package mls_pkg;
    localparam int PHASES    = 3;
    localparam int PAIRS     = 4;
    localparam int LEVELS    = PAIRS + 1;
    localparam int LVL_W     = $clog2(LEVELS);
    localparam int MID_LEVEL = PAIRS / 2;

    typedef logic [LVL_W-1:0] level_t;

    // upper switch k is on when the level reaches PAIRS-k
    function automatic logic [PAIRS-1:0] level_to_upper(level_t lvl);
        logic [PAIRS-1:0] up;
        for (int k = 0; k < PAIRS; k++) begin
            up[k] = (int'(lvl) >= (PAIRS - k));
        end
        return up;
    endfunction
endpackage

// File: rtl/mls_timebase.sv
module mls_timebase #(
    parameter int CNT_W      = 12,
    parameter int SEL_W      = 3,
    parameter int NOM_PERIOD = 1667,
    parameter int T1_BASE    = 30,
    parameter int T1_STEP    = 12,
    parameter int T2_BASE    = 150,
    parameter int T2_STEP    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] period_len,
    input  logic [SEL_W-1:0] mi_sel,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-1:0] n_o,
    output logic [CNT_W-1:0] third_o,
    output logic [CNT_W-1:0] t1_o,
    output logic [CNT_W-1:0] t2_o
);
    localparam int ENTRIES = 1 << SEL_W;
    localparam int CX_W    = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] n;
        logic [CNT_W-1:0] third;
        logic [CNT_W-1:0] t1;
        logic [CNT_W-1:0] t2;
    } tb_state_t;

    logic [CNT_W-1:0] rom_t1 [ENTRIES];
    logic [CNT_W-1:0] rom_t2 [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
        assign rom_t1[i] = CNT_W'(T1_BASE + T1_STEP * i);
        assign rom_t2[i] = CNT_W'(T2_BASE + T2_STEP * i);
    end

    tb_state_t s_d, s_q;
    logic      wrap;
    logic      load;

    always_comb begin
        s_d  = s_q;
        wrap = (CX_W'(s_q.pos) + CX_W'(1)) >= CX_W'(s_q.n);
        load = !run || (tick_en && wrap);
        if (!run) begin
            s_d.pos = '0;
        end else if (tick_en) begin
            s_d.pos = wrap ? '0 : s_q.pos + CNT_W'(1);
        end
        if (load) begin
            s_d.n     = period_len;
            s_d.third = period_len / CNT_W'(3);
            s_d.t1    = rom_t1[mi_sel];
            s_d.t2    = rom_t2[mi_sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pos   <= '0;
            s_q.n     <= CNT_W'(NOM_PERIOD);
            s_q.third <= CNT_W'(NOM_PERIOD / 3);
            s_q.t1    <= CNT_W'(T1_BASE);
            s_q.t2    <= CNT_W'(T2_BASE);
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_o   = s_q.pos;
    assign n_o     = s_q.n;
    assign third_o = s_q.third;
    assign t1_o    = s_q.t1;
    assign t2_o    = s_q.t2;
endmodule

// File: rtl/mls_phase_level.sv
module mls_phase_level
    import mls_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PHASE = 0
) (
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] n,
    input  logic [CNT_W-1:0] third,
    input  logic [CNT_W-1:0] t1,
    input  logic [CNT_W-1:0] t2,
    input  logic             run,
    output logic [PAIRS-1:0] want_up
);
    localparam int W = CNT_W + 1;

    logic [W-1:0] p_x, n_x, sh, ph, half, q, t1_x, t2_x;
    logic         neg;
    logic [1:0]   off;
    level_t       lvl;

    always_comb begin
        p_x  = W'(pos);
        n_x  = W'(n);
        t1_x = W'(t1);
        t2_x = W'(t2);
        sh   = W'(third) * W'(PHASE);
        // lagging copy of the common position, wrapped into the period
        ph   = (p_x >= sh) ? (p_x - sh) : (p_x + n_x - sh);
        half = n_x >> 1;
        if (ph < half) begin
            q   = ph;
            neg = 1'b0;
        end else begin
            q   = ph - half;
            neg = 1'b1;
        end
        if (q < t1_x) begin
            off = 2'd0;
        end else if (q < t2_x) begin
            off = 2'd1;
        end else if ((q + t2_x) < half) begin
            off = 2'd2;
        end else if ((q + t1_x) < half) begin
            off = 2'd1;
        end else begin
            off = 2'd0;
        end
        if (!run) begin
            lvl = level_t'(MID_LEVEL);
        end else if (neg) begin
            lvl = level_t'(MID_LEVEL) - level_t'(off);
        end else begin
            lvl = level_t'(MID_LEVEL) + level_t'(off);
        end
        want_up = level_to_upper(lvl);
    end
endmodule

// File: rtl/mls_deadband.sv
module mls_deadband #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic [DT_W-1:0] dead_ticks,
    input  logic            want,
    input  logic            force_off,
    output logic            out_hi,
    output logic            out_lo
);
    localparam int DX_W = DT_W + 1;

    typedef struct packed {
        logic            applied;
        logic            busy;
        logic [DT_W-1:0] cnt;
        logic            hi;
        logic            lo;
    } db_state_t;

    db_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (force_off || (want != s_q.applied)) begin
            s_d.applied = want;
            s_d.cnt     = '0;
            s_d.busy    = force_off || (dead_ticks != '0);
        end else if (s_q.busy) begin
            if (tick_en) begin
                if ((DX_W'(s_q.cnt) + DX_W'(1)) >= DX_W'(dead_ticks)) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + DT_W'(1);
                end
            end else if (s_q.cnt >= dead_ticks) begin
                s_d.busy = 1'b0;
            end
        end
        s_d.hi = !force_off && !s_d.busy && s_d.applied;
        s_d.lo = !force_off && !s_d.busy && !s_d.applied;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.applied <= 1'b0;
            s_q.busy    <= 1'b1;
            s_q.cnt     <= '0;
            s_q.hi      <= 1'b0;
            s_q.lo      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_hi = s_q.hi;
    assign out_lo = s_q.lo;
endmodule

// File: rtl/mls_gate_gen.sv
module mls_gate_gen
    import mls_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int SEL_W      = 3,
    parameter int DT_W       = 4,
    parameter int NOM_PERIOD = 1667
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_en,
    input  logic [CNT_W-1:0]          period_len,
    input  logic [SEL_W-1:0]          mi_sel,
    input  logic                      run,
    input  logic                      safe_off,
    input  logic [DT_W-1:0]           dead_ticks,
    output logic [PHASES*PAIRS-1:0]   gate_hi,
    output logic [PHASES*PAIRS-1:0]   gate_lo
);
    localparam int NG = PHASES * PAIRS;

    logic [CNT_W-1:0] pos_w, n_w, third_w, t1_w, t2_w;
    logic [NG-1:0]    want_w;

    mls_timebase #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .NOM_PERIOD(NOM_PERIOD)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
        .period_len(period_len), .mi_sel(mi_sel),
        .pos_o(pos_w), .n_o(n_w), .third_o(third_w), .t1_o(t1_w), .t2_o(t2_w)
    );

    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        mls_phase_level #(.CNT_W(CNT_W), .PHASE(ph)) u_level (
            .pos(pos_w), .n(n_w), .third(third_w), .t1(t1_w), .t2(t2_w),
            .run(run), .want_up(want_w[ph*PAIRS +: PAIRS])
        );
        for (genvar k = 0; k < PAIRS; k++) begin : g_pair
            mls_deadband #(.DT_W(DT_W)) u_db (
                .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
                .dead_ticks(dead_ticks), .want(want_w[ph*PAIRS+k]),
                .force_off(safe_off),
                .out_hi(gate_hi[ph*PAIRS+k]), .out_lo(gate_lo[ph*PAIRS+k])
            );
        end
    end
endmodule

// File: rtl/mls_gate_gen_sva.sv
module mls_gate_gen_sva #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 4,
    parameter int NG    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             run,
    input logic             safe_off,
    input logic [DT_W-1:0]  dead_ticks,
    input logic [NG-1:0]    gate_hi,
    input logic [NG-1:0]    gate_lo,
    input logic [CNT_W-1:0] pos,
    input logic [CNT_W-1:0] n
);
    localparam int CX_W = CNT_W + 1;

    // R1: gates are still at their reset value on the first active edge
    a_r1_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_hi == '0 && gate_lo == '0));

    // R7: a pair never conducts through both devices
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R9: safe-off opens every switch on the next clock
    a_r9_safe_off: assert property (@(posedge clk) disable iff (!rst_n)
        safe_off |=> (gate_hi == '0 && gate_lo == '0));

    // R6: with a nonzero interval a gate never rises while its partner was on
    a_r6_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dead_ticks) != '0) |->
        (((gate_hi & ~$past(gate_hi) & $past(gate_lo)) == '0) &&
         ((gate_lo & ~$past(gate_lo) & $past(gate_hi)) == '0)));

    // R5: no tick, no movement
    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_en) |=> $stable(pos));

    // R5: last position wraps to zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && ((CX_W'(pos) + CX_W'(1)) >= CX_W'(n))) |=> (pos == '0));
endmodule

bind mls_gate_gen mls_gate_gen_sva #(.CNT_W(CNT_W), .DT_W(DT_W), .NG(NG)) u_sva (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .safe_off(safe_off),
    .dead_ticks(dead_ticks), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .pos(pos_w), .n(n_w)
);

// File: tb/mls_gate_gen_bench.sv
module mls_gate_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 12;
    localparam int SEL_W = 3;
    localparam int DT_W  = 4;
    localparam int NG    = 12;
    localparam int NOM   = 1667;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, run = 1'b0, safe_off = 1'b0;
    logic [CNT_W-1:0] period_len = CNT_W'(NOM);
    logic [SEL_W-1:0] mi_sel = '0;
    logic [DT_W-1:0]  dead_ticks = '0;
    logic [NG-1:0]    gate_hi, gate_lo;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit checking = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mls_gate_gen u_mls_gate_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_len(period_len),
        .mi_sel(mi_sel), .run(run), .safe_off(safe_off), .dead_ticks(dead_ticks),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic fail(string req, string what, int act, int exp);
        n_fail++;
        if (n_fail <= 25)
            $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    function automatic int ref_level(int pos, int n, int third, int t1, int t2, int ph);
        int p, half, q, off;
        bit neg;
        p = pos - ph * third;
        if (p < 0) p += n;
        half = n / 2;
        if (p < half) begin q = p; neg = 0; end
        else begin q = p - half; neg = 1; end
        if (q < t1) off = 0;
        else if (q < t2) off = 1;
        else if (q < half - t2) off = 2;
        else if (q < half - t1) off = 1;
        else off = 0;
        return neg ? 2 - off : 2 + off;
    endfunction

    // reference model, state mirrors the requirements
    int m_pos, m_n, m_third, m_t1, m_t2;
    logic [NG-1:0] m_prev, e_hi, e_lo, e_set;
    int m_age [NG];
    string e_tag [NG];

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pos = 0; m_n = NOM; m_third = NOM / 3; m_t1 = 30; m_t2 = 150;
            m_prev = '0; e_hi = '0; e_lo = '0; e_set = '0;
            for (int g = 0; g < NG; g++) begin m_age[g] = 0; e_tag[g] = "R1"; end
        end else begin
            for (int g = 0; g < NG; g++) begin
                int lvl;
                bit w, settled;
                lvl = run ? ref_level(m_pos, m_n, m_third, m_t1, m_t2, g / 4) : 2;
                w = (lvl >= 4 - (g % 4));
                if (safe_off || w != m_prev[g]) m_age[g] = 0;
                else if (tick_en && m_age[g] < 100000) m_age[g]++;
                m_prev[g] = w;
                settled = !safe_off && (m_age[g] >= int'(dead_ticks));
                e_hi[g] = settled && w;
                e_lo[g] = settled && !w;
                e_set[g] = settled;
                e_tag[g] = safe_off ? "R9" : (!run ? "R8" : (!settled ? "R6" :
                           ((g / 4 == 0) ? "R3" : "R4")));
            end
            if (!run || (tick_en && m_pos + 1 >= m_n)) begin
                m_pos = 0; m_n = int'(period_len); m_third = int'(period_len) / 3;
                m_t1 = 30 + 12 * int'(mi_sel); m_t2 = 150 + 6 * int'(mi_sel);
            end else if (tick_en) begin
                m_pos++;
            end
        end
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n && checking) begin
            for (int g = 0; g < NG; g++) begin
                n_checks++;
                if (gate_hi[g] !== e_hi[g] || gate_lo[g] !== e_lo[g])
                    fail(e_tag[g], $sformatf("gate %0d hi/lo", g),
                         {gate_hi[g], gate_lo[g]}, {e_hi[g], e_lo[g]});
                if (e_set[g]) begin
                    n_checks++;
                    if (gate_lo[g] !== ~gate_hi[g])
                        fail("R2", $sformatf("gate %0d complement", g), gate_lo[g], ~gate_hi[g]);
                end
            end
            n_checks++;
            if ((gate_hi & gate_lo) != '0) fail("R7", "overlap", gate_hi & gate_lo, 0);
        end
    end

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_pos(int p);
        do @(negedge clk); while (m_pos != p);
    endtask

    initial begin
        logic [NG-1:0] snap;
        int rise [NG];
        void'($urandom(32'd4711));
        cyc(4);
        n_checks++;
        if (gate_hi != '0 || gate_lo != '0) fail("R1", "gates in reset", {gate_hi, gate_lo}, 0);
        rst_n = 1'b1;
        checking = 1'b1;
        // parked at mid level with run low
        cyc(20);
        n_checks++;
        if (gate_hi !== 12'hCCC) fail("R8", "parked upper pattern", gate_hi, 12'hCCC);
        // staircase run, no dead time
        tick_en = 1'b1; run = 1'b1;
        cyc(2 * NOM);
        // selection change mid-period waits for the wrap
        wait_pos(10); mi_sel = 3'd7;
        wait_pos(40);
        n_checks++;
        if (gate_hi[1] !== 1'b1) fail("R5", "old t1 still used", gate_hi[1], 1);
        wait_pos(40);
        n_checks++;
        if (gate_hi[1] !== 1'b0) fail("R5", "new t1 after wrap", gate_hi[1], 0);
        // selection and period change landing on the wrap itself
        wait_pos(m_n - 1); mi_sel = 3'd2; period_len = 12'd1900;
        cyc(NOM);
        // dead time, changed only during safe-off
        safe_off = 1'b1; dead_ticks = 4'd3; cyc(3); safe_off = 1'b0;
        cyc(2 * 1900);
        // one rise per device per period
        snap = gate_hi;
        for (int g = 0; g < NG; g++) rise[g] = 0;
        for (int i = 0; i < m_n; i++) begin
            @(negedge clk);
            for (int g = 0; g < NG; g++) if (gate_hi[g] && !snap[g]) rise[g]++;
            snap = gate_hi;
        end
        for (int g = 0; g < NG; g++) begin
            n_checks++;
            if (rise[g] != 1) fail("R10", $sformatf("rises of gate %0d", g), rise[g], 1);
        end
        // safe-off colliding with the start of a dead interval
        wait_pos(m_t1); safe_off = 1'b1; cyc(1);
        n_checks++;
        if (gate_hi != '0 || gate_lo != '0) fail("R9", "collision all off", {gate_hi, gate_lo}, 0);
        cyc(2); safe_off = 1'b0;
        cyc(2);
        // ticks held off: outputs frozen
        tick_en = 1'b0; cyc(3); snap = gate_hi;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n_checks++;
            if (gate_hi !== snap) fail("R5", "frozen without tick", gate_hi, snap);
        end
        tick_en = 1'b1;
        // stop and restart
        run = 1'b0; cyc(30);
        n_checks++;
        if (gate_hi !== 12'hCCC) fail("R8", "stopped upper pattern", gate_hi, 12'hCCC);
        run = 1'b1;
        // random stimulus
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            tick_en = ($urandom % 8) != 0;
            if ($urandom % 3000 == 0) begin
                mi_sel = SEL_W'($urandom);
                period_len = CNT_W'(1600 + $urandom % 401);
            end
            if ($urandom % 4000 == 0) begin
                safe_off = 1'b1;
                dead_ticks = DT_W'($urandom % 6);
                cyc(1 + $urandom % 4);
                safe_off = 1'b0;
            end
            if ($urandom % 9000 == 0) begin
                run = 1'b0; cyc(5 + $urandom % 20); run = 1'b1;
            end
        end
        cyc(5);
        finish_run();
    end
endmodule